// File: doc/BRIEF.md
# Write-Once Synchronising Storage Array

This block holds a small array of single-assignment storage cells for the producer/consumer handoff between operations in a dataflow machine. Every cell starts empty. A producer writes a cell exactly once. A consumer may ask for a cell's value before it has been written. Such an early request is not refused and does not stall the read port. Instead, the requester's tag is parked with the cell. When the value arrives, every parked requester receives the value automatically.

A response leaves on a single valid/ready channel that carries the requester's tag next to the data. Each requester therefore learns which of its outstanding requests has been answered. A clear request returns a cell to the empty state for reuse and discards any tags still parked there. Two sticky flags report misuse: writing a cell that is already filled, and parking more requesters on one cell than it has room for.

Top module: `istruct_mem`

## Requirements
- R1: After reset every cell is empty, `rsp_valid` is 0, and both error flags are 0.
- R2: A write to an empty cell stores `wr_data`, and the cell becomes filled. A later read of that cell returns that value.
- R3: A read of an unfilled cell is always accepted (`rd_ready` = 1) unless a clear of the same cell is presented in that cycle. The read produces no response until the cell is written.
- R4: When a cell holding parked tags is written, the parked requests are answered with the written value in their arrival order, one per cycle while `rsp_ready` = 1. The first answer appears in the cycle after the write edge.
- R5: A read accepted on a filled cell with no parked tags loads the response at the accepting edge, with `rsp_tag` = `rd_tag` and `rsp_data` = the stored value.
- R6: A write to a filled cell leaves the stored value unchanged and sets `err_double_write`, which stays set until reset.
- R7: Each cell parks at most `DEFER_DEPTH` (4) tags. A further early read to that cell is still accepted, but it is discarded and never answered, and it sets `err_overflow`, which stays set until reset.
- R8: While a filled cell still has parked tags to answer, new reads to that cell are refused (`rd_ready` = 0).
- R9: While `rsp_valid` = 1 and `rsp_ready` = 0, `rsp_valid`, `rsp_tag` and `rsp_data` hold their values.
- R10: A clear makes the addressed cell empty and discards its parked tags, so those tags are never answered. A clear takes priority over a write or read to the same cell in the same cycle, and that write is discarded.
- R11: Parked answers take priority over direct reads, and a direct read is refused while any cell is answering parked tags. Among cells, the lowest-numbered cell with parked tags is answered first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset, synchronous |
| wr_valid | input | 1 | Write request |
| wr_addr | input | ADDR_W (4) | Cell to write |
| wr_data | input | DATA_W (32) | Value to store |
| rd_valid | input | 1 | Read request |
| rd_ready | output | 1 | Read request accepted this cycle |
| rd_addr | input | ADDR_W (4) | Cell to read |
| rd_tag | input | TAG_W (4) | Requester tag, returned with the answer |
| clr_valid | input | 1 | Clear request |
| clr_addr | input | ADDR_W (4) | Cell to reclaim |
| rsp_valid | output | 1 | Response available |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_tag | output | TAG_W (4) | Tag of the answered request |
| rsp_data | output | DATA_W (32) | Value of the answered cell |
| err_double_write | output | 1 | Sticky: a filled cell was written again |
| err_overflow | output | 1 | Sticky: a parked-tag list overflowed |

## Verification
A direct read of a filled cell is loaded at the same edge that accepts it. A parked answer is loaded one edge after the edge that latches the write, because the cell must first show as filled before the drain selector can see it. Successive parked answers follow on successive edges. The error flags and the `rd_ready` refusal are visible one edge and zero edges after their cause, respectively. The bench drives inputs shortly after a rising edge and logs accepted responses on the falling edge, together with a rising-edge count. Each logged answer is therefore compared with the exact edge predicted from the request or write edge that the bench recorded.

// File: rtl/istruct_pkg.sv
package istruct_pkg;

   typedef enum logic [1:0] {
      CELL_ABSENT  = 2'd0,
      CELL_WAITING = 2'd1,
      CELL_PRESENT = 2'd2
   } cell_state_e;

endpackage

// File: rtl/istruct_cell.sv
// One write-once cell: presence state, stored value and a parked-tag FIFO.
module istruct_cell
   import istruct_pkg::*;
#(
   parameter  int DATA_W = 32,
   parameter  int TAG_W  = 4,
   parameter  int DEPTH  = 4,
   localparam int CNT_W  = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr_hit,
   input  logic              wr_hit,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              rd_hit,
   input  logic [TAG_W-1:0]  rd_tag,
   input  logic              pop,
   output cell_state_e       state_o,
   output logic [DATA_W-1:0] data_o,
   output logic [TAG_W-1:0]  head_tag_o,
   output logic [CNT_W-1:0]  cnt_o,
   output logic              dbl_wr_o,
   output logic              ovf_o
);

   cell_state_e       state_q;
   logic [DATA_W-1:0] data_q;
   logic [TAG_W-1:0]  tags_q [DEPTH];
   logic [CNT_W-1:0]  cnt_q;
   logic              unfilled;
   logic              full;
   logic              push;

   assign unfilled = (state_q != CELL_PRESENT);
   assign full     = (cnt_q == CNT_W'(DEPTH));
   assign push     = rd_hit && unfilled && !full && !clr_hit;
   assign ovf_o    = rd_hit && unfilled && full && !clr_hit;
   assign dbl_wr_o = wr_hit && !unfilled;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= CELL_ABSENT;
         data_q  <= '0;
         cnt_q   <= '0;
      end else if (clr_hit) begin
         state_q <= CELL_ABSENT;
         cnt_q   <= '0;
      end else begin
         if (wr_hit && unfilled) begin
            data_q  <= wr_data;
            state_q <= CELL_PRESENT;
         end else if (rd_hit && state_q == CELL_ABSENT) begin
            state_q <= CELL_WAITING;
         end
         if (push) begin
            cnt_q <= cnt_q + 1'b1;
         end else if (pop && cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
         end
      end
   end

   // Shift-down FIFO: slot 0 is the oldest parked tag.
   for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      if (i == DEPTH - 1) begin : g_tail
         always_ff @(posedge clk) begin
            if (push && cnt_q == CNT_W'(i)) begin
               tags_q[i] <= rd_tag;
            end
         end
      end else begin : g_body
         always_ff @(posedge clk) begin
            if (pop) begin
               tags_q[i] <= tags_q[i+1];
            end else if (push && cnt_q == CNT_W'(i)) begin
               tags_q[i] <= rd_tag;
            end
         end
      end
   end

   assign state_o    = state_q;
   assign data_o     = data_q;
   assign head_tag_o = tags_q[0];
   assign cnt_o      = cnt_q;

endmodule

// File: rtl/istruct_pick_first.sv
// Fixed-priority selector: lowest index wins.
module istruct_pick_first #(
   parameter  int N  = 16,
   localparam int IW = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]  req,
   output logic          any,
   output logic [IW-1:0] idx,
   output logic [N-1:0]  gnt
);

   always_comb begin
      idx = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req[i]) idx = IW'(i);
      end
      any = |req;
      gnt = '0;
      if (any) gnt[idx] = 1'b1;
   end

endmodule

// File: rtl/istruct_rsp_reg.sv
// Single-entry response register with valid/ready.
module istruct_rsp_reg #(
   parameter int DATA_W = 32,
   parameter int TAG_W  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [TAG_W-1:0]  ld_tag,
   input  logic [DATA_W-1:0] ld_data,
   input  logic              rsp_ready,
   output logic              can_load,
   output logic              rsp_valid,
   output logic [TAG_W-1:0]  rsp_tag,
   output logic [DATA_W-1:0] rsp_data
);

   assign can_load = !rsp_valid || rsp_ready;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_tag   <= '0;
         rsp_data  <= '0;
      end else if (load) begin
         rsp_valid <= 1'b1;
         rsp_tag   <= ld_tag;
         rsp_data  <= ld_data;
      end else if (rsp_ready) begin
         rsp_valid <= 1'b0;
      end
   end

endmodule

// File: rtl/istruct_mem.sv
module istruct_mem
   import istruct_pkg::*;
#(
   parameter  int NUM_CELLS   = 16,
   parameter  int DATA_W      = 32,
   parameter  int TAG_W       = 4,
   parameter  int DEFER_DEPTH = 4,
   localparam int ADDR_W      = $clog2(NUM_CELLS),
   localparam int CNT_W       = $clog2(DEFER_DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_valid,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              rd_valid,
   output logic              rd_ready,
   input  logic [ADDR_W-1:0] rd_addr,
   input  logic [TAG_W-1:0]  rd_tag,
   input  logic              clr_valid,
   input  logic [ADDR_W-1:0] clr_addr,
   output logic              rsp_valid,
   input  logic              rsp_ready,
   output logic [TAG_W-1:0]  rsp_tag,
   output logic [DATA_W-1:0] rsp_data,
   output logic              err_double_write,
   output logic              err_overflow
);

   if (NUM_CELLS < 2 || (NUM_CELLS & (NUM_CELLS - 1)) != 0) begin : g_bad_cells
      $error("istruct_mem: NUM_CELLS must be a power of two, at least 2");
   end
   if (DATA_W < 1 || TAG_W < 1) begin : g_bad_width
      $error("istruct_mem: DATA_W and TAG_W must be positive");
   end
   if (DEFER_DEPTH < 1) begin : g_bad_depth
      $error("istruct_mem: DEFER_DEPTH must be at least 1");
   end

   cell_state_e       st        [NUM_CELLS];
   logic [DATA_W-1:0] cell_data [NUM_CELLS];
   logic [TAG_W-1:0]  head_tag  [NUM_CELLS];
   logic [CNT_W-1:0]  cnt       [NUM_CELLS];

   logic [NUM_CELLS-1:0]        clr_hit, wr_hit, rd_hit, drain_req, gnt, pop;
   logic [NUM_CELLS-1:0]        dbl_v, ovf_v;
   logic [NUM_CELLS-1:0][1:0]   st_flat;
   logic                        drain_any, can_load, rd_fire, direct_ok, load;
   logic                        rd_clr_clash, sel_present;
   logic [ADDR_W-1:0]           gidx;
   logic [TAG_W-1:0]            ld_tag;
   logic [DATA_W-1:0]           ld_data;

   assign rd_clr_clash = clr_valid && (clr_addr == rd_addr);
   assign sel_present  = (st[rd_addr] == CELL_PRESENT);
   assign direct_ok    = sel_present && (cnt[rd_addr] == '0) && !drain_any && can_load;
   assign rd_ready     = !rd_clr_clash && (!sel_present || direct_ok);
   assign rd_fire      = rd_valid && rd_ready;

   for (genvar i = 0; i < NUM_CELLS; i++) begin : g_cell
      assign clr_hit[i]   = clr_valid && (clr_addr == ADDR_W'(i));
      assign wr_hit[i]    = wr_valid && (wr_addr == ADDR_W'(i)) && !clr_hit[i];
      assign rd_hit[i]    = rd_fire && (rd_addr == ADDR_W'(i)) && (st[i] != CELL_PRESENT);
      assign drain_req[i] = (st[i] == CELL_PRESENT) && (cnt[i] != '0) && !clr_hit[i];
      assign pop[i]       = gnt[i] && can_load;
      assign st_flat[i]   = st[i];

      istruct_cell #(
         .DATA_W (DATA_W),
         .TAG_W  (TAG_W),
         .DEPTH  (DEFER_DEPTH)
      ) u_cell (
         .clk        (clk),
         .rst_n      (rst_n),
         .clr_hit    (clr_hit[i]),
         .wr_hit     (wr_hit[i]),
         .wr_data    (wr_data),
         .rd_hit     (rd_hit[i]),
         .rd_tag     (rd_tag),
         .pop        (pop[i]),
         .state_o    (st[i]),
         .data_o     (cell_data[i]),
         .head_tag_o (head_tag[i]),
         .cnt_o      (cnt[i]),
         .dbl_wr_o   (dbl_v[i]),
         .ovf_o      (ovf_v[i])
      );
   end

   istruct_pick_first #(.N(NUM_CELLS)) u_pick (
      .req (drain_req),
      .any (drain_any),
      .idx (gidx),
      .gnt (gnt)
   );

   always_comb begin
      load    = (drain_any && can_load) || (rd_fire && sel_present);
      ld_tag  = drain_any ? head_tag[gidx]  : rd_tag;
      ld_data = drain_any ? cell_data[gidx] : cell_data[rd_addr];
   end

   istruct_rsp_reg #(.DATA_W(DATA_W), .TAG_W(TAG_W)) u_rsp (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (load),
      .ld_tag    (ld_tag),
      .ld_data   (ld_data),
      .rsp_ready (rsp_ready),
      .can_load  (can_load),
      .rsp_valid (rsp_valid),
      .rsp_tag   (rsp_tag),
      .rsp_data  (rsp_data)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         err_double_write <= 1'b0;
         err_overflow     <= 1'b0;
      end else begin
         if (|dbl_v) err_double_write <= 1'b1;
         if (|ovf_v) err_overflow     <= 1'b1;
      end
   end

endmodule

// File: rtl/istruct_mem_chk.sv
module istruct_mem_chk #(
   parameter int NUM_CELLS = 16,
   parameter int ADDR_W    = 4,
   parameter int DATA_W    = 32,
   parameter int TAG_W     = 4
) (
   input logic                      clk,
   input logic                      rst_n,
   input logic                      wr_valid,
   input logic [ADDR_W-1:0]         wr_addr,
   input logic                      rd_valid,
   input logic                      rd_ready,
   input logic [ADDR_W-1:0]         rd_addr,
   input logic [TAG_W-1:0]          rd_tag,
   input logic                      clr_valid,
   input logic [ADDR_W-1:0]         clr_addr,
   input logic                      rsp_valid,
   input logic                      rsp_ready,
   input logic [TAG_W-1:0]          rsp_tag,
   input logic [DATA_W-1:0]         rsp_data,
   input logic                      err_double_write,
   input logic                      err_overflow,
   input logic [NUM_CELLS-1:0][1:0] st_flat
);

   p_rsp_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_tag) && $stable(rsp_data));

   p_dbl_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
      err_double_write |=> err_double_write);

   p_ovf_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
      err_overflow |=> err_overflow);

   p_dbl_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
      wr_valid && !(clr_valid && clr_addr == wr_addr) && st_flat[wr_addr] == 2'd2
      |=> err_double_write);

   p_unfilled_accept_r3: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid && !(clr_valid && clr_addr == rd_addr) && st_flat[rd_addr] != 2'd2
      |-> rd_ready);

   p_direct_rsp_r5: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid && rd_ready && st_flat[rd_addr] == 2'd2
      |=> rsp_valid && rsp_tag == $past(rd_tag));

   p_write_fills_r2: assert property (@(posedge clk) disable iff (!rst_n)
      wr_valid && !(clr_valid && clr_addr == wr_addr)
      |=> st_flat[$past(wr_addr)] == 2'd2);

   p_clear_empties_r10: assert property (@(posedge clk) disable iff (!rst_n)
      clr_valid |=> st_flat[$past(clr_addr)] == 2'd0);

endmodule

bind istruct_mem istruct_mem_chk #(
   .NUM_CELLS (NUM_CELLS),
   .ADDR_W    (ADDR_W),
   .DATA_W    (DATA_W),
   .TAG_W     (TAG_W)
) u_chk (
   .clk              (clk),
   .rst_n            (rst_n),
   .wr_valid         (wr_valid),
   .wr_addr          (wr_addr),
   .rd_valid         (rd_valid),
   .rd_ready         (rd_ready),
   .rd_addr          (rd_addr),
   .rd_tag           (rd_tag),
   .clr_valid        (clr_valid),
   .clr_addr         (clr_addr),
   .rsp_valid        (rsp_valid),
   .rsp_ready        (rsp_ready),
   .rsp_tag          (rsp_tag),
   .rsp_data         (rsp_data),
   .err_double_write (err_double_write),
   .err_overflow     (err_overflow),
   .st_flat          (st_flat)
);

// File: tb/istruct_mem_tb.sv
`timescale 1ns/1ps
module istruct_mem_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_valid = 1'b0;
   logic [3:0]  wr_addr = '0;
   logic [31:0] wr_data = '0;
   logic        rd_valid = 1'b0;
   logic        rd_ready;
   logic [3:0]  rd_addr = '0;
   logic [3:0]  rd_tag = '0;
   logic        clr_valid = 1'b0;
   logic [3:0]  clr_addr = '0;
   logic        rsp_valid;
   logic        rsp_ready = 1'b1;
   logic [3:0]  rsp_tag;
   logic [31:0] rsp_data;
   logic        err_double_write;
   logic        err_overflow;

   int n_chk = 0;
   int n_fail = 0;
   int cyc = 0;

   logic [3:0]  cap_tag  [256];
   logic [31:0] cap_data [256];
   int          cap_cyc  [256];
   int          cap_n = 0;

   always #4 clk = ~clk;   // 125 MHz

   istruct_mem u_dut (
      .clk(clk), .rst_n(rst_n),
      .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr), .rd_tag(rd_tag),
      .clr_valid(clr_valid), .clr_addr(clr_addr),
      .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_tag(rsp_tag), .rsp_data(rsp_data),
      .err_double_write(err_double_write), .err_overflow(err_overflow)
   );

   always @(posedge clk) cyc <= cyc + 1;

   always @(negedge clk) begin
      if (rst_n && rsp_valid && rsp_ready && cap_n < 256) begin
         cap_tag[cap_n]  = rsp_tag;
         cap_data[cap_n] = rsp_data;
         cap_cyc[cap_n]  = cyc;
         cap_n++;
      end
   end

   function automatic logic [31:0] val(input int a);
      return (32'h1000_0001 * 32'(a + 3)) ^ 32'hC3C3_0000;
   endfunction

   task automatic check(input bit ok, input string req, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // All tasks start and end at posedge + 1 ns.
   task automatic step(input int n);
      repeat (n) begin @(posedge clk); #1; end
   endtask

   task automatic do_wr(input int a, input logic [31:0] d, output int ec);
      wr_valid = 1'b1; wr_addr = 4'(a); wr_data = d;
      @(posedge clk); #1; ec = cyc;
      wr_valid = 1'b0;
   endtask

   task automatic do_clr(input int a);
      clr_valid = 1'b1; clr_addr = 4'(a);
      @(posedge clk); #1;
      clr_valid = 1'b0;
   endtask

   task automatic do_rd(input int a, input int t, output bit acc, output int ec);
      rd_valid = 1'b1; rd_addr = 4'(a); rd_tag = 4'(t);
      #1 acc = rd_ready;
      @(posedge clk); #1; ec = cyc;
      rd_valid = 1'b0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

   initial begin
      bit acc;
      int ec, base, w0;
      int rd_ec [16];

      step(3);
      rst_n = 1'b1;
      step(1);

      // R1: reset state
      check(rsp_valid == 1'b0, "R1", "rsp_valid after reset", 64'(rsp_valid), 0);
      check(err_double_write == 1'b0 && err_overflow == 1'b0, "R1", "error flags after reset",
            64'({err_double_write, err_overflow}), 0);
      do_rd(0, 7, acc, ec);
      check(acc, "R1", "read of fresh cell accepted", 64'(acc), 1);
      step(6);
      check(cap_n == 0, "R3", "no answer for unwritten cell", 64'(cap_n), 0);
      do_clr(0);

      // R2/R5: write all cells, then read each directly
      for (int a = 0; a < 16; a++) do_wr(a, val(a), ec);
      base = cap_n;
      for (int a = 0; a < 16; a++) begin
         do_rd(a, a, acc, rd_ec[a]);
         check(acc, "R5", "direct read accepted", 64'(acc), 1);
      end
      step(3);
      check(cap_n - base == 16, "R5", "direct answer count", 64'(cap_n - base), 16);
      for (int a = 0; a < 16; a++) begin
         check(cap_tag[base+a] == 4'(a), "R5", "direct tag", 64'(cap_tag[base+a]), 64'(a));
         check(cap_data[base+a] == val(a), "R2", "stored value", 64'(cap_data[base+a]), 64'(val(a)));
         check(cap_cyc[base+a] == rd_ec[a], "R5", "direct answer edge",
               64'(cap_cyc[base+a]), 64'(rd_ec[a]));
      end

      // R6: double write
      do_wr(3, 32'hDEAD_BEEF, ec);
      check(err_double_write == 1'b1, "R6", "double write flag", 64'(err_double_write), 1);
      base = cap_n;
      do_rd(3, 2, acc, ec);
      step(2);
      check(cap_n - base == 1 && cap_data[base] == val(3), "R6", "value kept after double write",
            64'(cap_data[base]), 64'(val(3)));
      check(err_double_write == 1'b1, "R6", "double write flag sticky", 64'(err_double_write), 1);

      // R7/R8/R11/R4: parked reads, overflow, refusal during drain
      for (int a = 0; a < 16; a++) do_clr(a);
      do_wr(1, val(1), ec);
      base = cap_n;
      for (int t = 1; t <= 4; t++) begin
         do_rd(5, t, acc, ec);
         check(acc, "R3", "early read accepted", 64'(acc), 1);
      end
      check(err_overflow == 1'b0, "R7", "no overflow at capacity", 64'(err_overflow), 0);
      do_rd(5, 5, acc, ec);
      check(acc, "R7", "overflow read still accepted", 64'(acc), 1);
      check(err_overflow == 1'b1, "R7", "overflow flag", 64'(err_overflow), 1);
      check(cap_n == base, "R3", "parked reads unanswered", 64'(cap_n - base), 0);
      do_wr(5, 32'h5555_A0A0, w0);
      do_rd(5, 9, acc, ec);
      check(!acc, "R8", "read to draining cell refused", 64'(acc), 0);
      do_rd(1, 10, acc, ec);
      check(!acc, "R11", "direct read refused during drain", 64'(acc), 0);
      step(6);
      check(cap_n - base == 4, "R7", "only capacity answered", 64'(cap_n - base), 4);
      for (int k = 0; k < 4; k++) begin
         check(cap_tag[base+k] == 4'(k + 1), "R4", "parked tag order",
               64'(cap_tag[base+k]), 64'(k + 1));
         check(cap_data[base+k] == 32'h5555_A0A0, "R4", "parked value",
               64'(cap_data[base+k]), 64'h5555_A0A0);
         check(cap_cyc[base+k] == w0 + 1 + k, "R4", "parked answer edge",
               64'(cap_cyc[base+k]), 64'(w0 + 1 + k));
      end
      check(err_overflow == 1'b1, "R7", "overflow flag sticky", 64'(err_overflow), 1);
      base = cap_n;
      do_rd(1, 11, acc, ec);
      step(2);
      check(acc && cap_n - base == 1 && cap_data[base] == val(1), "R5", "direct read after drain",
            64'(cap_data[base]), 64'(val(1)));

      // R11/R4: two parked tags per cell, ascending writes
      for (int a = 0; a < 16; a++) do_clr(a);
      base = cap_n;
      for (int a = 0; a < 16; a++) begin
         do_rd(a, a, acc, ec);
         do_rd(a, 15 - a, acc, ec);
      end
      check(cap_n == base, "R3", "no answers before writes", 64'(cap_n - base), 0);
      do_wr(0, ~val(0), w0);
      for (int a = 1; a < 16; a++) do_wr(a, ~val(a), ec);
      step(24);
      check(cap_n - base == 32, "R4", "parked answer count", 64'(cap_n - base), 32);
      for (int i = 0; i < 32; i++) begin
         check(cap_tag[base+i] == ((i % 2 == 0) ? 4'(i / 2) : 4'(15 - i / 2)), "R11",
               "cross-cell order tag", 64'(cap_tag[base+i]),
               64'((i % 2 == 0) ? (i / 2) : (15 - i / 2)));
         check(cap_data[base+i] == ~val(i / 2), "R4", "cross-cell value",
               64'(cap_data[base+i]), 64'(~val(i / 2)));
         check(cap_cyc[base+i] == w0 + 1 + i, "R11", "cross-cell edge",
               64'(cap_cyc[base+i]), 64'(w0 + 1 + i));
      end

      // R9: back-pressure
      do_clr(7);
      base = cap_n;
      for (int t = 2; t <= 6; t += 2) do_rd(7, t, acc, ec);
      rsp_ready = 1'b0;
      do_wr(7, 32'h0707_7070, ec);
      step(3);
      check(rsp_valid && rsp_tag == 4'd2 && rsp_data == 32'h0707_7070, "R9", "held response",
            64'({rsp_valid, rsp_tag}), 64'({1'b1, 4'd2}));
      step(3);
      check(rsp_valid && rsp_tag == 4'd2 && rsp_data == 32'h0707_7070, "R9", "still held",
            64'({rsp_valid, rsp_tag}), 64'({1'b1, 4'd2}));
      check(cap_n == base, "R9", "nothing taken while stalled", 64'(cap_n - base), 0);
      rsp_ready = 1'b1;
      step(6);
      check(cap_n - base == 3 && cap_tag[base] == 4'd2 && cap_tag[base+1] == 4'd4 &&
            cap_tag[base+2] == 4'd6, "R9", "order after stall",
            64'({cap_tag[base], cap_tag[base+1], cap_tag[base+2]}), 64'h246);

      // R10: clear behaviour
      do_clr(9);
      base = cap_n;
      do_rd(9, 3, acc, ec);
      step(5);
      check(acc && cap_n == base, "R10", "cleared cell defers read", 64'(cap_n - base), 0);
      do_clr(9);
      do_wr(9, 32'h9999_0009, ec);
      step(5);
      check(cap_n == base, "R10", "cleared tags never answered", 64'(cap_n - base), 0);
      do_rd(9, 4, acc, ec);
      step(2);
      check(cap_n - base == 1 && cap_tag[base] == 4'd4 && cap_data[base] == 32'h9999_0009,
            "R10", "refilled after clear", 64'(cap_data[base]), 64'h9999_0009);
      base = cap_n;
      clr_valid = 1'b1; clr_addr = 4'd10;
      wr_valid = 1'b1; wr_addr = 4'd10; wr_data = 32'hBAD0_0010;
      rd_valid = 1'b1; rd_addr = 4'd10; rd_tag = 4'd13;
      #1 acc = rd_ready;
      @(posedge clk); #1;
      clr_valid = 1'b0; wr_valid = 1'b0; rd_valid = 1'b0;
      check(!acc, "R10", "read refused during same-cell clear", 64'(acc), 0);
      do_rd(10, 6, acc, ec);
      step(5);
      check(acc && cap_n == base, "R10", "write lost to same-cycle clear", 64'(cap_n - base), 0);
      do_wr(10, 32'h1010_ABCD, ec);
      step(3);
      check(cap_n - base == 1 && cap_tag[base] == 4'd6 && cap_data[base] == 32'h1010_ABCD,
            "R10", "cell refillable after clash", 64'(cap_data[base]), 64'h1010_ABCD);

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

endmodule